// File: doc/BRIEF.md
# Command Stream Register-Load Decoder

This block reads a byte-wide command stream from a FIFO and picks out register-load commands. A load begins with the opcode byte 0x61. Four more bytes follow. They are packed most significant byte first into a 32-bit word: the top byte selects a register and the low 24 bits are the value written to it. Bytes that arrive outside a load and are not the opcode are dropped and counted.

The block holds the configuration of a rectangle copy: the source origin and size, the destination address and row stride, and four filter coefficients. A load to the copy control index starts a copy only when a specific nibble of its value is all ones. The start comes out as a one-cycle pulse, together with a clear-enable qualifier. While the copy engine reports busy, the block stops taking bytes. A registered read port returns any stored register.

Top module: `regload_decoder`

## Requirements
- R1: An idle byte equal to 0x61 starts a load. Any other idle byte is dropped and increments `err_count` by one, saturating at all ones. A 0x61 byte inside a load's four value bytes is data, not an opcode.
- R2: The four bytes after the opcode form a word, first byte in bits 31..24. Bits 31..24 are the register index and bits 23..0 the value. The value is stored at the clock edge that accepts the fourth byte.
- R3: After reset, indices 0x01 to 0x04 read 0x666666, every other implemented register reads zero, `err_count` is zero and `copy_start` is low.
- R4: Index 0x4B (destination address) stores all 24 value bits.
- R5: Index 0x4D (destination row stride) stores only value bits 9..0. Its bits 23..10 read back as zero.
- R6: A load to index 0x52 whose value bits 15..12 are all 1 drives `copy_start` high for exactly one cycle, in the cycle after the fourth byte is accepted. `copy_clear` equals value bit 10 in that cycle and is low at every other time.
- R7: A load to index 0x52 with any of value bits 15..12 clear produces no `copy_start`.
- R8: A load to an unimplemented index changes no register and does not stall the stream. `in_ready` stays high, so the next load is accepted at once.
- R9: `in_ready` is low whenever `engine_busy` is high and during the `copy_start` cycle.
- R10: `rd_data` presents the register chosen by `rd_index` one clock edge after `rd_index` is set. Unimplemented indices, including 0x52, read zero.
- R11: Indices 0x49 (source origin) and 0x4A (source size) store all 24 value bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | FIFO byte available |
| in_data | input | 8 | FIFO byte |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| engine_busy | input | 1 | Copy engine still working |
| copy_start | output | 1 | One-cycle copy start pulse |
| copy_clear | output | 1 | Clear-enable qualifier, valid with copy_start |
| err_count | output | ERR_W | Saturating count of dropped idle bytes |
| rd_index | input | 8 | Register index to read |
| rd_data | output | 24 | Registered read data |

## Verification
Each check samples 1 ns after the clock edge it depends on. A stored value, the error count and the start pulse are all due right after the edge that accepts the relevant byte. The start pulse is checked at that point and again one cycle later, when it must be low again. Read-back takes one more edge, because `rd_index` is driven on the falling edge and `rd_data` is compared just after the next rising edge. The ready gating is sampled in the pulse cycle and during the engine's busy window.

// File: rtl/regload_pkg.sv
`timescale 1ns/1ps
package regload_pkg;
  localparam int VAL_W   = 24;
  localparam int IDX_W   = 8;
  localparam int WORD_W  = IDX_W + VAL_W;
  localparam int NSLOT   = 8;
  localparam int SLOT_W  = $clog2(NSLOT);
  localparam int NFILT   = 4;

  localparam logic [IDX_W-1:0] IDX_SRC_ORG    = 8'h49;
  localparam logic [IDX_W-1:0] IDX_SRC_DIM    = 8'h4A;
  localparam logic [IDX_W-1:0] IDX_DST_ADDR   = 8'h4B;
  localparam logic [IDX_W-1:0] IDX_DST_STRIDE = 8'h4D;
  localparam logic [IDX_W-1:0] IDX_COPY_CTL   = 8'h52;

  // copy control value layout: start nibble and clear flag
  localparam int START_LSB = 12;
  localparam int START_W   = 4;
  localparam int CLEAR_BIT = 10;

  // storage slot of the stride register
  localparam int STRIDE_SLOT = 7;

  typedef struct packed {
    logic              hit;
    logic [SLOT_W-1:0] slot;
  } slot_t;

  function automatic slot_t slot_of(input logic [IDX_W-1:0] idx);
    slot_t s;
    s.hit  = 1'b1;
    s.slot = '0;
    case (idx)
      8'h01:          s.slot = 3'd0;
      8'h02:          s.slot = 3'd1;
      8'h03:          s.slot = 3'd2;
      8'h04:          s.slot = 3'd3;
      IDX_SRC_ORG:    s.slot = 3'd4;
      IDX_SRC_DIM:    s.slot = 3'd5;
      IDX_DST_ADDR:   s.slot = 3'd6;
      IDX_DST_STRIDE: s.slot = 3'(STRIDE_SLOT);
      default:        s.hit  = 1'b0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/regload_assembler.sv
`timescale 1ns/1ps
module regload_assembler
  import regload_pkg::*;
#(
  parameter int               ERR_W  = 8,
  parameter logic [IDX_W-1:0] OPCODE = 8'h61
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [7:0]        in_data,
  output logic              word_valid,
  output logic [WORD_W-1:0] word,
  output logic [ERR_W-1:0]  err_count
);
  localparam int NBYTES = WORD_W / 8;
  localparam int CNT_W  = $clog2(NBYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES - 1);

  logic              in_load;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-9:0] shreg;

  assign word_valid = accept && in_load && (cnt == LAST);
  assign word       = {shreg, in_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      in_load   <= 1'b0;
      cnt       <= '0;
      shreg     <= '0;
      err_count <= '0;
    end else if (accept) begin
      if (!in_load) begin
        if (in_data == OPCODE) begin
          in_load <= 1'b1;
          cnt     <= '0;
        end else if (err_count != '1) begin
          err_count <= err_count + 1'b1;
        end
      end else begin
        shreg <= {shreg[WORD_W-17:0], in_data};
        cnt   <= cnt + 1'b1;
        if (cnt == LAST) in_load <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/regload_bank.sv
`timescale 1ns/1ps
module regload_bank
  import regload_pkg::*;
#(
  parameter logic [VAL_W-1:0] FILTER_INIT = 24'h666666,
  parameter int               STRIDE_W    = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [VAL_W-1:0] wdata,
  input  logic [IDX_W-1:0] rd_index,
  output logic [VAL_W-1:0] rd_data
);
  localparam logic [VAL_W-1:0] STRIDE_MASK =
    {{(VAL_W-STRIDE_W){1'b0}}, {STRIDE_W{1'b1}}};

  logic [VAL_W-1:0] init_val [NSLOT];
  logic [VAL_W-1:0] keep_mask [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot_const
    assign init_val[g]  = (g < NFILT) ? FILTER_INIT : '0;
    assign keep_mask[g] = (g == STRIDE_SLOT) ? STRIDE_MASK : '1;
  end

  logic [VAL_W-1:0] regs [NSLOT];
  slot_t wmap, rmap;

  always_comb begin
    wmap = slot_of(widx);
    rmap = slot_of(rd_index);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NSLOT; i++) begin
      if (rst)
        regs[i] <= init_val[i];
      else if (we && wmap.hit && wmap.slot == SLOT_W'(i))
        regs[i] <= wdata & keep_mask[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           rd_data <= '0;
    else if (rmap.hit) rd_data <= regs[rmap.slot];
    else               rd_data <= '0;
  end
endmodule

// File: rtl/regload_copyctl.sv
`timescale 1ns/1ps
module regload_copyctl
  import regload_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               word_valid,
  input  logic [IDX_W-1:0]   widx,
  input  logic [START_W-1:0] start_field,
  input  logic               clear_flag,
  output logic               copy_start,
  output logic               copy_clear
);
  logic fire;
  assign fire = word_valid && (widx == IDX_COPY_CTL) && (&start_field);

  always_ff @(posedge clk) begin
    if (rst) begin
      copy_start <= 1'b0;
      copy_clear <= 1'b0;
    end else begin
      copy_start <= fire;
      copy_clear <= fire && clear_flag;
    end
  end
endmodule

// File: rtl/regload_decoder.sv
`timescale 1ns/1ps
module regload_decoder
  import regload_pkg::*;
#(
  parameter int               ERR_W       = 8,
  parameter logic [IDX_W-1:0] OPCODE      = 8'h61,
  parameter logic [VAL_W-1:0] FILTER_INIT = 24'h666666,
  parameter int               STRIDE_W    = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  input  logic             engine_busy,
  output logic             copy_start,
  output logic             copy_clear,
  output logic [ERR_W-1:0] err_count,
  input  logic [IDX_W-1:0] rd_index,
  output logic [VAL_W-1:0] rd_data
);
  logic              accept;
  logic              word_valid;
  logic [WORD_W-1:0] word;

  assign in_ready = !engine_busy && !copy_start;
  assign accept   = in_valid && in_ready;

  regload_assembler #(.ERR_W(ERR_W), .OPCODE(OPCODE)) u_asm (
    .clk(clk), .rst(rst), .accept(accept), .in_data(in_data),
    .word_valid(word_valid), .word(word), .err_count(err_count)
  );

  regload_bank #(.FILTER_INIT(FILTER_INIT), .STRIDE_W(STRIDE_W)) u_bank (
    .clk(clk), .rst(rst), .we(word_valid),
    .widx(word[WORD_W-1:VAL_W]), .wdata(word[VAL_W-1:0]),
    .rd_index(rd_index), .rd_data(rd_data)
  );

  regload_copyctl u_ctl (
    .clk(clk), .rst(rst), .word_valid(word_valid),
    .widx(word[WORD_W-1:VAL_W]),
    .start_field(word[START_LSB+START_W-1:START_LSB]),
    .clear_flag(word[CLEAR_BIT]),
    .copy_start(copy_start), .copy_clear(copy_clear)
  );
endmodule

// File: rtl/regload_checker.sv
`timescale 1ns/1ps
module regload_checker
  import regload_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             engine_busy,
  input logic             copy_start,
  input logic             copy_clear,
  input logic [ERR_W-1:0] err_count,
  input logic [IDX_W-1:0] rd_index,
  input logic [VAL_W-1:0] rd_data
);
  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    copy_start |=> !copy_start);

  assert_clear_qualified_R6: assert property (@(posedge clk) disable iff (rst)
    copy_clear |-> copy_start);

  assert_ready_gated_R9: assert property (@(posedge clk) disable iff (rst)
    (engine_busy || copy_start) |-> !in_ready);

  assert_err_saturates_R1: assert property (@(posedge clk) disable iff (rst)
    (&err_count) |=> (&err_count));

  assert_err_step_R1: assert property (@(posedge clk) disable iff (rst)
    !(&err_count) |=> (err_count == $past(err_count)) ||
                      (err_count == $past(err_count) + 1'b1));

  assert_stride_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_index == IDX_DST_STRIDE) |=> (rd_data[VAL_W-1:10] == '0));

  assert_ctl_reads_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_index == IDX_COPY_CTL) |=> (rd_data == '0));
endmodule

bind regload_decoder regload_checker #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .engine_busy(engine_busy),
  .copy_start(copy_start), .copy_clear(copy_clear), .err_count(err_count),
  .rd_index(rd_index), .rd_data(rd_data)
);

// File: tb/regload_decoder_test.sv
`timescale 1ns/1ps
module regload_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic        engine_busy = 1'b0;
  logic        copy_start, copy_clear;
  logic [7:0]  err_count;
  logic [7:0]  rd_index = 8'h00;
  logic [23:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit engine_on = 0;

  always #2.5 clk = ~clk;

  regload_decoder uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .engine_busy(engine_busy),
    .copy_start(copy_start), .copy_clear(copy_clear),
    .err_count(err_count), .rd_index(rd_index), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // copy engine model: busy for four cycles after a start pulse
  initial begin
    int left = 0;
    forever begin
      @(negedge clk);
      if (engine_on && copy_start) left = 4;
      else if (left > 0) left--;
      engine_busy = (left > 0);
    end
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic send_load(input logic [7:0] idx, input logic [23:0] val);
    send_byte(8'h61);
    send_byte(idx);
    send_byte(val[23:16]);
    send_byte(val[15:8]);
    send_byte(val[7:0]);
  endtask

  task automatic read_reg(input string tag, input logic [7:0] idx, input logic [23:0] exp);
    @(negedge clk);
    rd_index = idx;
    @(posedge clk);
    #1;
    chk(tag, {8'h0, rd_data}, {8'h0, exp});
  endtask

  task automatic t_reset;
    chk("R3 err_count", {24'h0, err_count}, 32'h0);
    chk("R3 copy_start", {31'h0, copy_start}, 32'h0);
    chk("R9 in_ready idle", {31'h0, in_ready}, 32'h1);
    for (int i = 1; i <= 4; i++) read_reg("R3 filter default", 8'(i), 24'h666666);
    read_reg("R3 src origin zero", 8'h49, 24'h0);
    read_reg("R3 dst addr zero", 8'h4B, 24'h0);
    read_reg("R3 stride zero", 8'h4D, 24'h0);
  endtask

  task automatic t_loads;
    send_load(8'h4B, 24'hABCDEF);
    read_reg("R4 dst addr", 8'h4B, 24'hABCDEF);
    send_load(8'h49, 24'h123456);
    send_load(8'h4A, 24'h0FEDCB);
    read_reg("R11 src origin", 8'h49, 24'h123456);
    read_reg("R11 src size", 8'h4A, 24'h0FEDCB);
    send_load(8'h02, 24'h010203);
    read_reg("R2 filter write", 8'h02, 24'h010203);
    read_reg("R2 other filter kept", 8'h03, 24'h666666);
  endtask

  task automatic t_stride;
    send_load(8'h4D, 24'hFFFFFF);
    read_reg("R5 stride masked", 8'h4D, 24'h0003FF);
    send_load(8'h4D, 24'hC00155);
    read_reg("R5 stride low bits", 8'h4D, 24'h000155);
  endtask

  task automatic t_junk;
    send_byte(8'h00);
    send_byte(8'h55);
    send_byte(8'h62);
    chk("R1 dropped bytes counted", {24'h0, err_count}, 32'd3);
    send_load(8'h4B, 24'h616161);
    chk("R1 0x61 in value is data", {24'h0, err_count}, 32'd3);
    read_reg("R2 value with 0x61 bytes", 8'h4B, 24'h616161);
  endtask

  task automatic t_unmapped;
    send_load(8'h30, 24'h777777);
    chk("R8 no stall after unmapped", {31'h0, in_ready}, 32'h1);
    send_load(8'h49, 24'h000042);
    read_reg("R8 next load accepted", 8'h49, 24'h000042);
    read_reg("R10 unmapped reads zero", 8'h30, 24'h0);
    read_reg("R8 dst addr untouched", 8'h4B, 24'h616161);
    read_reg("R10 control reads zero", 8'h52, 24'h0);
  endtask

  task automatic t_copy;
    engine_on = 1;
    send_load(8'h52, 24'h00F400);
    chk("R6 start pulse", {31'h0, copy_start}, 32'h1);
    chk("R6 clear flag set", {31'h0, copy_clear}, 32'h1);
    chk("R9 ready low in pulse", {31'h0, in_ready}, 32'h0);
    @(posedge clk);
    #1;
    chk("R6 pulse one cycle", {31'h0, copy_start}, 32'h0);
    chk("R6 clear low after", {31'h0, copy_clear}, 32'h0);
    chk("R9 busy engine", {31'h0, engine_busy}, 32'h1);
    chk("R9 ready low while busy", {31'h0, in_ready}, 32'h0);
    send_load(8'h52, 24'h00F000);
    chk("R6 second start", {31'h0, copy_start}, 32'h1);
    chk("R6 clear flag clear", {31'h0, copy_clear}, 32'h0);
    send_load(8'h52, 24'h00EFFF);
    chk("R7 nibble 1110 no start", {31'h0, copy_start}, 32'h0);
    @(posedge clk);
    #1;
    chk("R7 still no start", {31'h0, copy_start}, 32'h0);
    send_load(8'h52, 24'h007400);
    chk("R7 nibble 0111 no start", {31'h0, copy_start}, 32'h0);
    engine_on = 0;
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 300; i++) send_byte(8'h00);
    chk("R1 err saturates", {24'h0, err_count}, 32'hFF);
    send_load(8'h01, 24'h00ABCD);
    read_reg("R2 load after saturation", 8'h01, 24'h00ABCD);
    chk("R1 err held at max", {24'h0, err_count}, 32'hFF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    t_reset();
    t_loads();
    t_stride();
    t_junk();
    t_unmapped();
    t_copy();
    t_saturate();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule